// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block passes commands from a 16-bit host bus to an 8-bit microcontroller and carries replies back. The host stores a 16-bit command word, which raises an interrupt toward the microcontroller. The host then polls two status words. One tells it when the command has been taken. The other tells it when a reply is waiting. It reads the reply from a data word.

The microcontroller sees the block as three byte ports. Two data ports assemble an outgoing 16-bit reply, low byte and high byte. A control port carries two handshake bits, and a falling edge on either bit starts a transfer. A falling edge on bit 0 takes the command: it drops the interrupt and presents the command bytes on the two port inputs. A falling edge on bit 1 publishes the assembled reply to the host.

A parameter can swap the two bytes of every host command before it is stored, to suit hosts with the opposite byte order.

Top module: `mcu_mailbox`

## Requirements
- R1: After reset the interrupt is low, both semaphores are clear (status words read 0xFFFF), the reply word reads 0x0000 and the port inputs present 0x00.
- R2: A host write at word offset 0 stores the command under byte enables (enable bit 0 for bits 7:0, enable bit 1 for bits 15:8), sets the command semaphore and raises the interrupt on the next cycle. While the command semaphore is set, offset 2 reads 0xFFFE.
- R3: With SWAP_BYTES=1 the write data has its bytes exchanged before the byte enables apply. With SWAP_BYTES=0 it is stored as written.
- R4: A control-port write that takes bit 0 from 1 to 0 clears the command semaphore and the interrupt. It also loads the command's bits 7:0 onto port A input and bits 15:8 onto port B input. Offset 2 then reads 0xFFFF.
- R5: A control-port write with no falling edge on bit 0 leaves the interrupt and the port inputs unchanged.
- R6: Port A writes set reply bits 7:0 and port B writes set reply bits 15:8. A control-port write that takes bit 1 from 1 to 0 copies the reply into the host reply word and sets the reply semaphore. Offset 3 then reads 0xFFFE; with no reply pending it reads 0xFFFF.
- R7: A host read strobe at offset 0 returns the reply word and clears the reply semaphore. A read flagged as debug returns the same value and leaves the semaphore set.
- R8: Reads at offsets other than 0, 2 and 3 return 0xFFFF. Status words hold bits 15:1 at one. Host writes at offsets other than 0 change nothing.
- R9: When a host command write and a bit-0 falling edge happen in the same cycle, the semaphore and interrupt end up set. When a bit-1 falling edge and a reply read happen in the same cycle, the reply semaphore ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host word offset |
| host_rd | input | 1 | Host read strobe (carries side effects) |
| host_dbg | input | 1 | Marks the read as side-effect free |
| host_rdata | output | 16 | Host read data, combinational on host_addr |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Host byte enables |
| host_wdata | input | 16 | Host write data |
| mcu_irq | output | 1 | Interrupt to the microcontroller |
| mcu_pa_wr | input | 1 | Microcontroller write to port A |
| mcu_pb_wr | input | 1 | Microcontroller write to port B |
| mcu_pc_wr | input | 1 | Microcontroller write to the control port |
| mcu_wdata | input | 8 | Microcontroller port write data |
| mcu_pa_in | output | 8 | Port A input value (command bits 7:0) |
| mcu_pb_in | output | 8 | Port B input value (command bits 15:8) |

## Verification
The assertions check the cycle-level handshake rules on every cycle. The interrupt tracks the command semaphore. A command write raises the interrupt. A bit-0 falling edge lowers it, unless a write lands in the same cycle. A control write with no such edge leaves the port inputs still. A bit-1 edge sets the reply flag, and a debug read never clears it. Status words keep their upper fifteen bits at one.

Only the bench scenarios can show data correctness. That covers the byte-enable merge and the swapped byte order of the stored command, and how the two reply bytes are assembled. It also covers the exact values read back at each offset after a full command and reply exchange.

// File: rtl/mcu_mailbox.sv
module mcu_mailbox #(
  parameter bit          SWAP_BYTES = 1'b0,
  parameter int          ADDR_W     = 3,
  parameter logic [2:0]  OFS_REPLY  = 3'd0,
  parameter logic [2:0]  OFS_CMDST  = 3'd2,
  parameter logic [2:0]  OFS_RPLST  = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_dbg,
  output logic [15:0]       host_rdata,
  input  logic              host_wr,
  input  logic [1:0]        host_be,
  input  logic [15:0]       host_wdata,
  output logic              mcu_irq,
  input  logic              mcu_pa_wr,
  input  logic              mcu_pb_wr,
  input  logic              mcu_pc_wr,
  input  logic [7:0]        mcu_wdata,
  output logic [7:0]        mcu_pa_in,
  output logic [7:0]        mcu_pb_in
);

  localparam logic [15:0] ALL_ONES = 16'hFFFF;

  logic [15:0] cmd_q, reply_q, outgo_q;
  logic [1:0]  ctl_q;
  logic        cmd_sem, rpl_sem;

  logic [15:0] wdata_ord;
  logic        cmd_wr, take_cmd, post_rpl, rpl_ack;

  assign wdata_ord = SWAP_BYTES ? {host_wdata[7:0], host_wdata[15:8]} : host_wdata;
  assign cmd_wr    = host_wr && (host_addr == ADDR_W'(OFS_REPLY));
  assign take_cmd  = mcu_pc_wr && ctl_q[0] && !mcu_wdata[0];
  assign post_rpl  = mcu_pc_wr && ctl_q[1] && !mcu_wdata[1];
  assign rpl_ack   = host_rd && !host_dbg && (host_addr == ADDR_W'(OFS_REPLY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_wr) begin
      if (host_be[0]) cmd_q[7:0]  <= wdata_ord[7:0];
      if (host_be[1]) cmd_q[15:8] <= wdata_ord[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_sem <= 1'b0;
      mcu_irq <= 1'b0;
    end else if (cmd_wr) begin
      cmd_sem <= 1'b1;
      mcu_irq <= 1'b1;
    end else if (take_cmd) begin
      cmd_sem <= 1'b0;
      mcu_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcu_pa_in <= '0;
      mcu_pb_in <= '0;
    end else if (take_cmd) begin
      mcu_pa_in <= cmd_q[7:0];
      mcu_pb_in <= cmd_q[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outgo_q <= '0;
    end else begin
      if (mcu_pa_wr) outgo_q[7:0]  <= mcu_wdata;
      if (mcu_pb_wr) outgo_q[15:8] <= mcu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (mcu_pc_wr) begin
      ctl_q <= mcu_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_q <= '0;
      rpl_sem <= 1'b0;
    end else if (post_rpl) begin
      reply_q <= outgo_q;
      rpl_sem <= 1'b1;
    end else if (rpl_ack) begin
      rpl_sem <= 1'b0;
    end
  end

  always_comb begin
    if (host_addr == ADDR_W'(OFS_REPLY))
      host_rdata = reply_q;
    else if (host_addr == ADDR_W'(OFS_CMDST))
      host_rdata = {ALL_ONES[15:1], !cmd_sem};
    else if (host_addr == ADDR_W'(OFS_RPLST))
      host_rdata = {ALL_ONES[15:1], !rpl_sem};
    else
      host_rdata = ALL_ONES;
  end

  p_irq_tracks_sem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_irq == cmd_sem);

  p_write_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(OFS_REPLY)) |=> mcu_irq);

  p_take_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_pc_wr && ctl_q[0] && !mcu_wdata[0] && !host_wr) |=> !mcu_irq);

  p_no_edge_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_pc_wr && !(ctl_q[0] && !mcu_wdata[0]) && !host_wr)
      |=> ($stable(mcu_irq) && $stable(mcu_pa_in) && $stable(mcu_pb_in)));

  p_post_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_pc_wr && ctl_q[1] && !mcu_wdata[1]) |=> (host_addr != ADDR_W'(OFS_RPLST) || !host_rdata[0] || rpl_sem));

  p_debug_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_dbg && rpl_sem) |=> rpl_sem);

  p_status_high_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr != ADDR_W'(OFS_REPLY)) |-> (&host_rdata[15:1]));

endmodule

// File: tb/mcu_mailbox_test.sv
module mcu_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_dbg = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_be = '0;
  logic [15:0] host_wdata = '0;
  logic        mcu_pa_wr = 1'b0, mcu_pb_wr = 1'b0, mcu_pc_wr = 1'b0;
  logic [7:0]  mcu_wdata = '0;
  logic [15:0] rdata, rdata_s;
  logic        irq, irq_s;
  logic [7:0]  pa_in, pb_in, pa_in_s, pb_in_s;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mcu_mailbox #(.SWAP_BYTES(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_dbg(host_dbg), .host_rdata(rdata), .host_wr(host_wr),
    .host_be(host_be), .host_wdata(host_wdata), .mcu_irq(irq),
    .mcu_pa_wr(mcu_pa_wr), .mcu_pb_wr(mcu_pb_wr), .mcu_pc_wr(mcu_pc_wr),
    .mcu_wdata(mcu_wdata), .mcu_pa_in(pa_in), .mcu_pb_in(pb_in));

  mcu_mailbox #(.SWAP_BYTES(1'b1)) uut_swap (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_dbg(host_dbg), .host_rdata(rdata_s), .host_wr(host_wr),
    .host_be(host_be), .host_wdata(host_wdata), .mcu_irq(irq_s),
    .mcu_pa_wr(mcu_pa_wr), .mcu_pb_wr(mcu_pb_wr), .mcu_pc_wr(mcu_pc_wr),
    .mcu_wdata(mcu_wdata), .mcu_pa_in(pa_in_s), .mcu_pb_in(pb_in_s));

  // ops: 0 write be=11, 8 write be=01, 9 write be=10, 10 write offset 1,
  // 1 port A, 2 port B, 3 control, 4 read, 5 debug read,
  // 6 check {pb_in,pa_in}, 7 check irq, 11 check swapped {pb_in,pa_in}
  localparam int NV = 50;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {4'd1, 4'd7,  16'h0000, 16'h0000},   // R1
    {4'd1, 4'd4,  16'h0002, 16'hFFFF},   // R1
    {4'd1, 4'd4,  16'h0003, 16'hFFFF},   // R1
    {4'd1, 4'd4,  16'h0000, 16'h0000},   // R1
    {4'd1, 4'd6,  16'h0000, 16'h0000},   // R1
    {4'd2, 4'd0,  16'h1234, 16'h0000},   // R2
    {4'd2, 4'd7,  16'h0000, 16'h0001},   // R2
    {4'd2, 4'd4,  16'h0002, 16'hFFFE},   // R2
    {4'd5, 4'd3,  16'h0003, 16'h0000},   // R5 rising edges only
    {4'd5, 4'd7,  16'h0000, 16'h0001},   // R5
    {4'd5, 4'd6,  16'h0000, 16'h0000},   // R5
    {4'd4, 4'd3,  16'h0002, 16'h0000},   // R4 bit 0 falls
    {4'd4, 4'd7,  16'h0000, 16'h0000},   // R4
    {4'd4, 4'd6,  16'h0000, 16'h1234},   // R4
    {4'd4, 4'd4,  16'h0002, 16'hFFFF},   // R4
    {4'd3, 4'd11, 16'h0000, 16'h3412},   // R3
    {4'd6, 4'd1,  16'h00CD, 16'h0000},   // R6
    {4'd6, 4'd2,  16'h00AB, 16'h0000},   // R6
    {4'd6, 4'd4,  16'h0003, 16'hFFFF},   // R6 nothing posted yet
    {4'd6, 4'd3,  16'h0000, 16'h0000},   // R6 bit 1 falls
    {4'd6, 4'd4,  16'h0003, 16'hFFFE},   // R6
    {4'd7, 4'd5,  16'h0000, 16'hABCD},   // R7 debug read
    {4'd7, 4'd4,  16'h0003, 16'hFFFE},   // R7 still pending
    {4'd7, 4'd4,  16'h0000, 16'hABCD},   // R7 real read
    {4'd7, 4'd4,  16'h0003, 16'hFFFF},   // R7 cleared
    {4'd8, 4'd4,  16'h0001, 16'hFFFF},   // R8
    {4'd8, 4'd4,  16'h0005, 16'hFFFF},   // R8
    {4'd8, 4'd4,  16'h0007, 16'hFFFF},   // R8
    {4'd8, 4'd10, 16'hBEEF, 16'h0000},   // R8 write elsewhere
    {4'd8, 4'd7,  16'h0000, 16'h0000},   // R8
    {4'd8, 4'd4,  16'h0002, 16'hFFFF},   // R8
    {4'd2, 4'd8,  16'h5678, 16'h0000},   // R2 low byte only
    {4'd2, 4'd3,  16'h0001, 16'h0000},   // R2
    {4'd2, 4'd3,  16'h0000, 16'h0000},   // R2
    {4'd2, 4'd6,  16'h0000, 16'h1278},   // R2
    {4'd3, 4'd11, 16'h0000, 16'h3456},   // R3
    {4'd2, 4'd9,  16'h9A00, 16'h0000},   // R2 high byte only
    {4'd2, 4'd3,  16'h0001, 16'h0000},   // R2
    {4'd2, 4'd3,  16'h0000, 16'h0000},   // R2
    {4'd2, 4'd6,  16'h0000, 16'h9A78},   // R2
    {4'd3, 4'd11, 16'h0000, 16'h0056},   // R3
    {4'd6, 4'd1,  16'h0011, 16'h0000},   // R6
    {4'd6, 4'd3,  16'h0002, 16'h0000},   // R6 rising bit 1
    {4'd6, 4'd4,  16'h0003, 16'hFFFF},   // R6
    {4'd6, 4'd3,  16'h0000, 16'h0000},   // R6 bit 1 falls
    {4'd6, 4'd4,  16'h0000, 16'hAB11},   // R6
    {4'd6, 4'd4,  16'h0003, 16'hFFFF},   // R6 read above cleared it
    {4'd5, 4'd3,  16'h0000, 16'h0000},   // R5 no edge
    {4'd5, 4'd7,  16'h0000, 16'h0000},   // R5
    {4'd5, 4'd6,  16'h0000, 16'h9A78}    // R5
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    host_rd = 0; host_dbg = 0; host_wr = 0; host_be = 0;
    mcu_pa_wr = 0; mcu_pb_wr = 0; mcu_pc_wr = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [3:0] req, op;
      logic [15:0] a, e;
      {req, op, a, e} = VEC[i];
      @(negedge clk);
      clear_strobes();
      case (op)
        4'd0, 4'd8, 4'd9, 4'd10: begin
          host_wr = 1; host_wdata = a;
          host_addr = (op == 4'd10) ? 3'd1 : 3'd0;
          host_be = (op == 4'd8) ? 2'b01 : (op == 4'd9) ? 2'b10 : 2'b11;
        end
        4'd1: begin mcu_pa_wr = 1; mcu_wdata = a[7:0]; end
        4'd2: begin mcu_pb_wr = 1; mcu_wdata = a[7:0]; end
        4'd3: begin mcu_pc_wr = 1; mcu_wdata = a[7:0]; end
        4'd4: begin host_rd = 1; host_addr = a[2:0]; end
        4'd5: begin host_rd = 1; host_dbg = 1; host_addr = a[2:0]; end
        default: ;
      endcase
      #1;
      case (op)
        4'd4, 4'd5: chk(int'(req), rdata, e);
        4'd6:  chk(int'(req), {pb_in, pa_in}, e);
        4'd7:  chk(int'(req), {15'd0, irq}, e);
        4'd11: chk(int'(req), {pb_in_s, pa_in_s}, e);
        default: ;
      endcase
    end

    // R9: command write and bit-0 falling edge in the same cycle
    @(negedge clk); clear_strobes();
    mcu_pc_wr = 1; mcu_wdata = 8'h01;
    @(negedge clk); clear_strobes();
    mcu_pc_wr = 1; mcu_wdata = 8'h00;
    host_wr = 1; host_addr = 3'd0; host_be = 2'b11; host_wdata = 16'h4444;
    @(negedge clk); clear_strobes();
    host_addr = 3'd2;
    #1;
    chk(9, {15'd0, irq}, 16'h0001);
    chk(9, rdata, 16'hFFFE);
    chk(9, {pb_in, pa_in}, 16'h9A78);

    // R9: reply post and reply read in the same cycle
    @(negedge clk); clear_strobes();
    mcu_pc_wr = 1; mcu_wdata = 8'h02;
    @(negedge clk); clear_strobes();
    mcu_pc_wr = 1; mcu_wdata = 8'h00;
    host_rd = 1; host_addr = 3'd0;
    @(negedge clk); clear_strobes();
    host_addr = 3'd3;
    #1;
    chk(9, rdata, 16'hFFFE);
    host_addr = 3'd0;
    #1;
    chk(9, rdata, 16'hAB11);

    @(negedge clk); clear_strobes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule